// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit resolves one conditional-branch instruction per valid cycle. It receives the 32-bit instruction word, the two source operand values already read from the register file, and a flag that says whether 16-bit compressed instructions are enabled. The unit holds the program counter itself, and that registered value is the address of the branch being resolved.

For each accepted word the unit rebuilds the branch displacement from its scattered bit fields and picks one of six comparisons. It adds the sign-extended displacement to the program counter to form the target. Then it decides among four outcomes: jump, fall through, misaligned-fetch fault, or illegal instruction. The outcome, the updated program counter and the decoded source register indices all appear on registered outputs one cycle after the input. The fault report also carries the offending target address.

Operand width is set by the `XLEN` parameter (32 or 64). The value loaded by reset is set by the `RESET_PC` parameter.

Top module: `branch_resolve_unit`

## Requirements
- R1: The displacement is a 13-bit two's-complement value whose bit 0 is always zero. Its bit 12 comes from instr[31], bit 11 from instr[7], bits 10..5 from instr[30:25] and bits 4..1 from instr[11:8].
- R2: The source register indices come from the word: the first from instr[19:15] and the second from instr[24:20]. They appear on `src_a_idx` and `src_b_idx` one cycle after a valid input.
- R3: instr[14:12] selects the comparison of operand A with operand B. 000 is equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than and 111 unsigned greater-or-equal. `taken` reports the outcome, and it is also set when the jump then faults.
- R4: The target is the current program counter plus the displacement sign-extended to XLEN bits, with wrap-around.
- R5: A taken branch that does not fault loads the target into the program counter.
- R6: A branch that is not taken advances the program counter by 4 and raises no fault. This holds even when its computed target has bit 1 set.
- R7: A taken branch faults when its target has bit 1 set and compressed instructions are disabled. `misalign_fault` is then high for one cycle, `fault_addr` carries the target, and the program counter is unchanged.
- R8: With compressed instructions enabled, a taken branch to a target that is only 2-byte aligned is legal and jumps.
- R9: A word is illegal when its opcode instr[6:0] is not 1100011, or when instr[14:12] is 010 or 011. An illegal word raises `illegal` for one cycle, clears `taken` and `misalign_fault`, and leaves the program counter unchanged.
- R10: A synchronous active-high reset loads `RESET_PC` into the program counter and clears `out_valid`, `taken`, `illegal`, `misalign_fault` and `fault_addr`.
- R11: Every registered output reflects the input of the previous cycle. After a cycle with `in_valid` low, `out_valid`, `taken`, `illegal` and `misalign_fault` are low, `fault_addr` is zero and the program counter holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are present this cycle |
| instr | input | 32 | Branch instruction word |
| src_a_val | input | XLEN | Value of the first source register |
| src_b_val | input | XLEN | Value of the second source register |
| compressed_en | input | 1 | 16-bit instructions enabled; relaxes target alignment to 2 bytes |
| out_valid | output | 1 | A result from the previous cycle is present |
| pc | output | XLEN | Registered program counter |
| taken | output | 1 | Comparison held for the resolved branch |
| illegal | output | 1 | Resolved word was not a legal conditional branch |
| misalign_fault | output | 1 | Taken branch hit a target not aligned to 4 bytes while compressed instructions were disabled |
| fault_addr | output | XLEN | Faulting target; zero otherwise |
| src_a_idx | output | 5 | First source register index of the last valid word |
| src_b_idx | output | 5 | Second source register index of the last valid word |

## Verification
Every result of this block is due exactly one rising edge after the cycle that presented the word. That covers the flags, the fault address, the register indices and the new program counter. The driver applies a word half a period before an edge and queues the outcome it predicts from the program counter it tracks itself. The monitor wakes 2 ns after each rising edge and retires one queued item, so every comparison lands in the cycle the result is due. Idle cycles are queued too, which checks that nothing carries over into the cycle after.

// File: rtl/brc_pkg.sv
package brc_pkg;

  localparam int unsigned OFF_W = 13;
  localparam logic [6:0] OPC_COND_BRANCH = 7'b1100011;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'b000,
    CMP_NE  = 3'b001,
    CMP_LT  = 3'b100,
    CMP_GE  = 3'b101,
    CMP_LTU = 3'b110,
    CMP_GEU = 3'b111
  } cmp_kind_e;

  // Reassemble the displacement; bit 0 is implicitly zero.
  function automatic logic [OFF_W-1:0] gather_offset(input logic [31:0] w);
    return {w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  // Function codes 010 and 011 select no comparison.
  function automatic logic bad_cmp_code(input logic [2:0] f);
    return f[2:1] == 2'b01;
  endfunction

endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
(
  input  logic [31:0]      instr,
  output logic [OFF_W-1:0] offset,
  output cmp_kind_e        kind,
  output logic [4:0]       idx_a,
  output logic [4:0]       idx_b,
  output logic             bad_word
);
  assign offset   = gather_offset(instr);
  assign kind     = cmp_kind_e'(instr[14:12]);
  assign idx_a    = instr[19:15];
  assign idx_b    = instr[24:20];
  assign bad_word = (instr[6:0] != OPC_COND_BRANCH) || bad_cmp_code(instr[14:12]);
endmodule

// File: rtl/brc_compare.sv
module brc_compare
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  cmp_kind_e       kind,
  output logic            met
);
  always_comb begin
    unique case (kind)
      CMP_EQ:  met = (opa == opb);
      CMP_NE:  met = (opa != opb);
      CMP_LT:  met = ($signed(opa) <  $signed(opb));
      CMP_GE:  met = ($signed(opa) >= $signed(opb));
      CMP_LTU: met = (opa <  opb);
      CMP_GEU: met = (opa >= opb);
      default: met = 1'b0;
    endcase
  end
endmodule

// File: rtl/brc_target.sv
module brc_target
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target
);
  localparam int unsigned EXT_W = XLEN - OFF_W;

  function automatic logic [XLEN-1:0] widen(input logic [OFF_W-1:0] o);
    return {{EXT_W{o[OFF_W-1]}}, o};
  endfunction

  assign target = cur_pc + widen(offset);
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brc_pkg::*;
#(
  parameter int unsigned    XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a_val,
  input  logic [XLEN-1:0] src_b_val,
  input  logic            compressed_en,
  output logic            out_valid,
  output logic [XLEN-1:0] pc,
  output logic            taken,
  output logic            illegal,
  output logic            misalign_fault,
  output logic [XLEN-1:0] fault_addr,
  output logic [4:0]      src_a_idx,
  output logic [4:0]      src_b_idx
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [OFF_W-1:0] dec_offset;
  cmp_kind_e        dec_kind;
  logic [4:0]       dec_idx_a, dec_idx_b;
  logic             dec_bad;
  logic             cond_met;
  logic [XLEN-1:0]  cand_target;
  logic             take_br;
  logic             target_fault;
  logic [XLEN-1:0]  seq_pc;
  logic [XLEN-1:0]  next_pc;

  brc_decode u_decode (
    .instr    (instr),
    .offset   (dec_offset),
    .kind     (dec_kind),
    .idx_a    (dec_idx_a),
    .idx_b    (dec_idx_b),
    .bad_word (dec_bad)
  );

  brc_compare #(.XLEN(XLEN)) u_compare (
    .opa  (src_a_val),
    .opb  (src_b_val),
    .kind (dec_kind),
    .met  (cond_met)
  );

  brc_target #(.XLEN(XLEN)) u_target (
    .cur_pc (pc),
    .offset (dec_offset),
    .target (cand_target)
  );

  assign take_br      = !dec_bad && cond_met;
  assign target_fault = take_br && cand_target[1] && !compressed_en;
  assign seq_pc       = pc + INSN_BYTES;

  always_comb begin
    next_pc = pc;
    if (in_valid && !dec_bad && !target_fault)
      next_pc = take_br ? cand_target : seq_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc             <= RESET_PC;
      out_valid      <= 1'b0;
      taken          <= 1'b0;
      illegal        <= 1'b0;
      misalign_fault <= 1'b0;
      fault_addr     <= '0;
      src_a_idx      <= '0;
      src_b_idx      <= '0;
    end else begin
      pc             <= next_pc;
      out_valid      <= in_valid;
      taken          <= in_valid && take_br;
      illegal        <= in_valid && dec_bad;
      misalign_fault <= in_valid && target_fault;
      fault_addr     <= (in_valid && target_fault) ? cand_target : '0;
      if (in_valid) begin
        src_a_idx <= dec_idx_a;
        src_b_idx <= dec_idx_b;
      end
    end
  end
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [2:0]      fn_code,
  input logic            compressed_en,
  input logic            out_valid,
  input logic [XLEN-1:0] pc,
  input logic            taken,
  input logic            illegal,
  input logic            misalign_fault,
  input logic [XLEN-1:0] fault_addr
);
  // R7
  fault_holds_pc_chk: assert property (@(posedge clk) disable iff (rst)
    misalign_fault |-> (pc == $past(pc)) && fault_addr[1] && taken);

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !taken && !misalign_fault && (pc == $past(pc)));

  // R3
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fn_code[2:1] == 2'b01) |=> illegal);

  // R6
  fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !taken && !illegal) |-> !misalign_fault && (pc == $past(pc) + XLEN'(4)));

  // R8
  compressed_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && compressed_en) |=> !misalign_fault);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !taken && !illegal && !misalign_fault && (pc == $past(pc)));

  // R10
  reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == RESET_PC) && !out_valid);
endmodule

bind branch_resolve_unit brc_checker #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .fn_code        (instr[14:12]),
  .compressed_en  (compressed_en),
  .out_valid      (out_valid),
  .pc             (pc),
  .taken          (taken),
  .illegal        (illegal),
  .misalign_fault (misalign_fault),
  .fault_addr     (fault_addr)
);

// File: tb/branch_resolve_unit_test.sv
module branch_resolve_unit_test;
  localparam logic [31:0] BOOT = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src_a_val = '0, src_b_val = '0;
  logic        compressed_en = 1'b0;
  logic        out_valid, taken, illegal, misalign_fault;
  logic [31:0] pc, fault_addr;
  logic [4:0]  src_a_idx, src_b_idx;

  always #4 clk = ~clk;

  branch_resolve_unit #(.XLEN(32), .RESET_PC(BOOT)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_a_val(src_a_val), .src_b_val(src_b_val), .compressed_en(compressed_en),
    .out_valid(out_valid), .pc(pc), .taken(taken), .illegal(illegal),
    .misalign_fault(misalign_fault), .fault_addr(fault_addr),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx)
  );

  typedef struct {
    logic v, tk, il, mi;
    logic [31:0] tv, npc;
    logic [4:0] ia, ib;
  } exp_t;

  exp_t q[$];
  int vectors = 0, miscompares = 0;
  logic [31:0] model_pc;
  logic [4:0]  last_ia = '0, last_ib = '0;
  bit finished = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Build a word from a displacement: the inverse of the field split.
  function automatic logic [31:0] mk(input logic [12:0] d, input logic [4:0] a, input logic [4:0] b, input logic [2:0] f);
    return {d[12], d[10:5], b, a, f, d[4:1], d[11], 7'b1100011};
  endfunction

  function automatic exp_t predict(input logic v, input logic [31:0] w, input logic [31:0] ra,
                                   input logic [31:0] rb, input logic ce);
    exp_t e;
    logic [12:0] d;
    logic [31:0] tgt;
    logic ok, hit;
    e.v = v; e.tk = 0; e.il = 0; e.mi = 0; e.tv = 0; e.npc = model_pc;
    e.ia = last_ia; e.ib = last_ib;
    if (!v) return e;
    e.ia = w[19:15]; e.ib = w[24:20];
    d = {w[31], w[7], w[30:25], w[11:8], 1'b0};
    tgt = model_pc + {{19{d[12]}}, d};
    ok = (w[6:0] == 7'b1100011) && (w[14:12] != 3'd2) && (w[14:12] != 3'd3);
    case (w[14:12])
      3'd0: hit = ra == rb;
      3'd1: hit = ra != rb;
      3'd4: hit = $signed(ra) < $signed(rb);
      3'd5: hit = !($signed(ra) < $signed(rb));
      3'd6: hit = ra < rb;
      3'd7: hit = !(ra < rb);
      default: hit = 0;
    endcase
    if (!ok) begin
      e.il = 1;
    end else if (hit) begin
      e.tk = 1;
      if (tgt[1] && !ce) begin e.mi = 1; e.tv = tgt; end
      else e.npc = tgt;
    end else begin
      e.npc = model_pc + 32'd4;
    end
    return e;
  endfunction

  task automatic apply(input logic v, input logic [31:0] w, input logic [31:0] ra,
                       input logic [31:0] rb, input logic ce);
    exp_t e;
    @(negedge clk);
    in_valid = v; instr = w; src_a_val = ra; src_b_val = rb; compressed_en = ce;
    e = predict(v, w, ra, rb, ce);
    q.push_back(e);
    model_pc = e.npc; last_ia = e.ia; last_ib = e.ib;
  endtask

  // Monitor: results are due one edge after the driving cycle.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check("R11", "out_valid", {31'd0, out_valid}, {31'd0, e.v});
      check("R3 R5 R6", "taken", {31'd0, taken}, {31'd0, e.tk});
      check("R9", "illegal", {31'd0, illegal}, {31'd0, e.il});
      check("R7 R8", "misalign_fault", {31'd0, misalign_fault}, {31'd0, e.mi});
      check("R4 R7", "fault_addr", fault_addr, e.tv);
      check("R1 R4 R5 R6", "pc", pc, e.npc);
      if (e.v) begin
        check("R2", "src_a_idx", {27'd0, src_a_idx}, {27'd0, e.ia});
        check("R2", "src_b_idx", {27'd0, src_b_idx}, {27'd0, e.ib});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_pc = BOOT;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10: state after reset
    check("R10", "pc after reset", pc, BOOT);
    check("R10", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R10", "flags after reset", {29'd0, taken, illegal, misalign_fault}, 32'd0);
    check("R10", "fault_addr after reset", fault_addr, 32'd0);

    apply(1, mk(13'd16, 5'd3, 5'd4, 3'b000), 32'd7, 32'd7, 0);            // R3 eq taken
    apply(1, mk(13'd16, 5'd5, 5'd6, 3'b001), 32'd7, 32'd7, 0);            // R6 ne not taken
    apply(1, mk(-13'sd8, 5'd1, 5'd2, 3'b100), 32'hFFFF_FFFF, 32'd1, 0);   // R3 signed lt
    apply(1, mk(13'd20, 5'd1, 5'd2, 3'b101), 32'hFFFF_FFFF, 32'd1, 0);    // R3 signed ge fails
    apply(1, mk(13'h0FFC, 5'd9, 5'd10, 3'b110), 32'd1, 32'hFFFF_FFFF, 0); // R3 unsigned lt, max +
    apply(1, mk(13'h1000, 5'd9, 5'd10, 3'b111), 32'hFFFF_FFFF, 32'd1, 0); // R4 most negative
    apply(1, mk(13'd6, 5'd11, 5'd12, 3'b000), 32'd5, 32'd5, 0);           // R7 fault
    apply(0, 32'd0, 32'd0, 32'd0, 0);                                     // R11 idle
    apply(1, mk(13'd6, 5'd11, 5'd12, 3'b000), 32'd5, 32'd6, 0);           // R6 misaligned not taken
    apply(1, mk(13'd6, 5'd13, 5'd14, 3'b000), 32'd5, 32'd5, 1);           // R8 halfword legal
    apply(1, mk(13'd8, 5'd1, 5'd1, 3'b010), 32'd0, 32'd0, 0);             // R9 code 010
    apply(1, mk(13'd8, 5'd1, 5'd1, 3'b011), 32'd0, 32'd0, 0);             // R9 code 011
    apply(1, mk(13'd8, 5'd1, 5'd1, 3'b000) ^ 32'h1, 32'd0, 32'd0, 0);     // R9 bad opcode
    apply(1, mk(-13'sd2, 5'd2, 5'd3, 3'b000), 32'd0, 32'd0, 1);           // R1 R4 negative halfword

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w, a, b;
      w = $urandom;
      if (($urandom % 8) != 0) w[6:0] = 7'b1100011;
      a = $urandom;
      b = (($urandom % 3) == 0) ? a : $urandom;
      apply(($urandom % 6) != 0, w, a, b, $urandom % 2);
    end

    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule